// File: doc/BRIEF.md
# Converter Test Pattern Generator

This block sits between a converter's sample stream and the transport layer of a multi-lane serial link. It replaces real samples with known 16-bit words, so that a receiver can check the link end to end. A small write-only register port selects the pattern mode and holds four user pattern words.

The block tracks a `data_phase` input, which is high while the link carries sample data. The first sample produced after that input rises is the first word of the pattern. The user-pattern sequence can repeat without end. It can also run once: the four words go out a single time, zeros follow, and a done flag is raised.

The sequence starts again whenever the link re-enters the data phase after a resynchronization, and whenever the mode register is written. New user words are staged and only used when the sequence starts again. A sequence that has already begun therefore always sends the words it started with.

Top module: `conv_test_pattern_gen`

## Requirements
- R1: With mode code 0x0, `tx_sample` equals the `adc_sample` value of the previous clock cycle, whether or not the link is in the data phase.
- R2: With mode code 0x1, each data-phase sample alternates between 0x5555 and 0xAAAA, and the first sample after a restart is 0x5555.
- R3: With mode code 0xE, data-phase samples follow user words 1, 2, 3, 4 and then wrap back to word 1, without end.
- R4: With mode code 0xF, data-phase samples are user words 1 to 4 exactly once, and 0x0000 on every sample after that.
- R5: The sequence restarts in two cases: after any cycle with `data_phase` low, and after a write to the mode register. The output in the cycle after a mode write is 0x0000.
- R6: In any non-zero mode, the output is 0x0000 for samples outside the data phase. A mode code other than 0x0, 0x1, 0xE and 0xF outputs 0x0000.
- R7: A write to a user word while a sequence is running does not change the words that sequence sends. The new value is used from the next restart.
- R8: `single_done` is high only in mode 0xF. It rises together with the fourth user word and stays high until the sequence restarts.
- R9: Register map: address 0 holds the mode in data bits 3:0, and addresses 1 to 4 hold user words 1 to 4. After reset, `tx_sample` is 0x0000, `single_done` is low, the mode is 0x0 and all user words are 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| data_phase | input | 1 | High while the link carries sample data |
| adc_sample | input | 16 | Real converter sample |
| tx_sample | output | 16 | Sample word sent to the transport layer |
| single_done | output | 1 | The single-shot sequence has sent all four words |

## Verification
The assertions assume that `data_phase` and the register port are driven only away from the clock edge. They also assume that a mode write and a data-phase sample may occur in the same cycle, and that the write then takes precedence. The stimulus changes every input at the falling edge and issues at most one register write per cycle. It includes mode rewrites and user-word writes both in the middle of a data phase and during idle gaps, so the restart and staging rules are tested under the conditions the properties rely on.

// File: rtl/conv_test_pattern_gen.sv
module conv_test_pattern_gen #(
  parameter int SW = 16,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [SW-1:0] cfg_wdata,
  input  logic          data_phase,
  input  logic [SW-1:0] adc_sample,
  output logic [SW-1:0] tx_sample,
  output logic          single_done
);

  localparam logic [MW-1:0] M_PASS = MW'(4'h0);
  localparam logic [MW-1:0] M_CHK  = MW'(4'h1);
  localparam logic [MW-1:0] M_LOOP = MW'(4'hE);
  localparam logic [MW-1:0] M_ONCE = MW'(4'hF);
  localparam logic [SW-1:0] CHK_A  = {(SW/2){2'b01}};
  localparam logic [SW-1:0] CHK_B  = ~CHK_A;

  logic [MW-1:0] mode_q;
  logic [SW-1:0] stage_q [4];
  logic [SW-1:0] live_q  [4];
  logic [2:0]    pos_q, pos_nx;
  logic [SW-1:0] word;

  wire mode_wr = cfg_we && (cfg_addr == 3'd0);
  wire user_wr = cfg_we && (cfg_addr != 3'd0) && (cfg_addr <= 3'd4);

  always_comb begin
    case (mode_q)
      M_PASS:  word = adc_sample;
      M_CHK:   word = pos_q[0] ? CHK_B : CHK_A;
      M_LOOP:  word = live_q[pos_q[1:0]];
      M_ONCE:  word = pos_q[2] ? '0 : live_q[pos_q[1:0]];
      default: word = '0;
    endcase
  end

  assign pos_nx = (mode_q == M_ONCE) ? (pos_q[2] ? pos_q : pos_q + 3'd1)
                                     : {1'b0, pos_q[1:0] + 2'd1};

  assign single_done = (mode_q == M_ONCE) && pos_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_PASS;
      pos_q     <= '0;
      tx_sample <= '0;
      for (int i = 0; i < 4; i++) begin
        stage_q[i] <= '0;
        live_q[i]  <= '0;
      end
    end else begin
      if (user_wr) stage_q[cfg_addr[1:0] - 2'd1] <= cfg_wdata;
      if (mode_wr || !data_phase)
        for (int i = 0; i < 4; i++) live_q[i] <= stage_q[i];
      if (mode_wr) begin
        mode_q    <= cfg_wdata[MW-1:0];
        pos_q     <= '0;
        tx_sample <= '0;
      end else if (!data_phase) begin
        pos_q     <= '0;
        tx_sample <= (mode_q == M_PASS) ? adc_sample : '0;
      end else begin
        pos_q     <= pos_nx;
        tx_sample <= word;
      end
    end
  end

  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PASS && !mode_wr) |=> tx_sample == $past(adc_sample));

  assert_chk_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_CHK && data_phase && !mode_wr && pos_q == 3'd0) |=> tx_sample == CHK_A);

  assert_chk_values_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_CHK && data_phase && !mode_wr) |=> (tx_sample == CHK_A || tx_sample == CHK_B));

  assert_once_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (single_done && data_phase && !mode_wr) |=> (tx_sample == '0 && single_done));

  assert_wr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (tx_sample == '0 && !single_done));

  assert_idle_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |=> !single_done);

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_phase && mode_q != M_PASS) |=> tx_sample == '0);

endmodule

// File: tb/test_conv_test_pattern_gen.sv
`timescale 1ns/1ps
module test_conv_test_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        data_phase = 1'b0;
  logic [15:0] adc_sample = '0;
  logic [15:0] tx_sample;
  logic        single_done;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] tx;
    logic        done;
    string       req;
  } exp_t;
  exp_t q[$];

  localparam logic [15:0] U1 = 16'h3B1B, U2 = 16'h7654, U3 = 16'hC0DE, U4 = 16'hFEDC;
  localparam logic [15:0] N1 = 16'hABCD;

  always #2 clk = ~clk;

  conv_test_pattern_gen i_conv_test_pattern_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .data_phase(data_phase), .adc_sample(adc_sample),
    .tx_sample(tx_sample), .single_done(single_done)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (tx_sample !== e.tx || single_done !== e.done) begin
        errors++;
        $display("FAIL %s: tx=%h done=%b expected tx=%h done=%b",
                 e.req, tx_sample, single_done, e.tx, e.done);
      end
    end
  end

  task automatic step(input logic dp, input logic [15:0] adc, input logic we,
                      input logic [2:0] a, input logic [15:0] d,
                      input logic [15:0] etx, input logic edone, input string req);
    @(negedge clk);
    data_phase = dp; adc_sample = adc;
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    q.push_back('{etx, edone, req});
  endtask

  task automatic run(input logic dp, input logic [15:0] etx, input logic edone, input string req);
    step(dp, 16'h0F0F, 1'b0, 3'd0, 16'h0, etx, edone, req);
  endtask

  task automatic wr(input logic dp, input logic [2:0] a, input logic [15:0] d,
                    input logic [15:0] etx, input logic edone, input string req);
    step(dp, 16'h0011, 1'b1, a, d, etx, edone, req);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (tx_sample !== 16'h0 || single_done !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: tx=%h done=%b expected tx=0000 done=0", tx_sample, single_done);
    end
    // R1 pass-through outside and inside the data phase
    step(1'b0, 16'h1234, 1'b0, 3'd0, 16'h0, 16'h1234, 1'b0, "R1 idle");
    step(1'b1, 16'h0BEE, 1'b0, 3'd0, 16'h0, 16'h0BEE, 1'b0, "R1 data");
    // R9 user words at addresses 1..4
    wr(1'b0, 3'd1, U1, 16'h0011, 1'b0, "R9 wr1");
    wr(1'b0, 3'd2, U2, 16'h0011, 1'b0, "R9 wr2");
    wr(1'b0, 3'd3, U3, 16'h0011, 1'b0, "R9 wr3");
    wr(1'b0, 3'd4, U4, 16'h0011, 1'b0, "R9 wr4");
    // R2 checkerboard
    wr(1'b0, 3'd0, 16'h1, 16'h0, 1'b0, "R5 mode write");
    run(1'b0, 16'h0, 1'b0, "R6 idle chk");
    run(1'b1, 16'h5555, 1'b0, "R2 s0");
    run(1'b1, 16'hAAAA, 1'b0, "R2 s1");
    run(1'b1, 16'h5555, 1'b0, "R2 s2");
    run(1'b1, 16'hAAAA, 1'b0, "R2 s3");
    // R3 continuous
    wr(1'b0, 3'd0, 16'hE, 16'h0, 1'b0, "R5 mode write");
    run(1'b1, U1, 1'b0, "R3 w1");
    run(1'b1, U2, 1'b0, "R3 w2");
    run(1'b1, U3, 1'b0, "R3 w3");
    run(1'b1, U4, 1'b0, "R3 w4");
    run(1'b1, U1, 1'b0, "R3 wrap1");
    run(1'b1, U2, 1'b0, "R3 wrap2");
    // R7 staged user update mid-sequence
    wr(1'b1, 3'd1, N1, U3, 1'b0, "R7 write during run");
    run(1'b1, U4, 1'b0, "R7 old w4");
    run(1'b1, U1, 1'b0, "R7 old w1");
    run(1'b0, 16'h0, 1'b0, "R6 idle loop");
    run(1'b1, N1, 1'b0, "R7 new w1");
    run(1'b1, U2, 1'b0, "R5 restart w2");
    // R6 unsupported code
    wr(1'b0, 3'd0, 16'h7, 16'h0, 1'b0, "R5 mode write");
    run(1'b1, 16'h0, 1'b0, "R6 unknown code");
    // R4 / R8 single shot
    wr(1'b0, 3'd0, 16'hF, 16'h0, 1'b0, "R5 mode write");
    run(1'b1, N1, 1'b0, "R4 w1");
    run(1'b1, U2, 1'b0, "R4 w2");
    run(1'b1, U3, 1'b0, "R4 w3");
    run(1'b1, U4, 1'b1, "R8 done with w4");
    run(1'b1, 16'h0, 1'b1, "R4 zero1");
    run(1'b1, 16'h0, 1'b1, "R4 zero2");
    run(1'b1, 16'h0, 1'b1, "R4 zero3");
    run(1'b0, 16'h0, 1'b0, "R8 cleared idle");
    run(1'b1, N1, 1'b0, "R5 rearm w1");
    run(1'b1, U2, 1'b0, "R5 rearm w2");
    wr(1'b1, 3'd0, 16'hF, 16'h0, 1'b0, "R5 rewrite mid-run");
    run(1'b1, N1, 1'b0, "R5 rewrite w1");
    run(1'b1, U2, 1'b0, "R5 rewrite w2");
    run(1'b1, U3, 1'b0, "R5 rewrite w3");
    run(1'b1, U4, 1'b1, "R8 rewrite done");
    // back to pass-through
    wr(1'b1, 3'd0, 16'h0, 16'h0, 1'b0, "R5 mode write");
    step(1'b1, 16'h5A5A, 1'b0, 3'd0, 16'h0, 16'h5A5A, 1'b0, "R1 after patterns");
    step(1'b0, 16'hA5A5, 1'b0, 3'd0, 16'h0, 16'hA5A5, 1'b0, "R1 idle again");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule